// File: doc/BRIEF.md
# Synchronous Serial Shift-Register Port

This block is a half-duplex serial port that moves one byte per transfer over two pins: a single bidirectional data line (driven through `sd_out` with the enable `sd_oe`, observed on `sd_in`) and a shift-clock output `sclk_out` that the port always generates itself. A peer device on the other end is a plain shift register clocked by `sclk_out`. Each bit takes a fixed number of core clocks. The shift clock is low for the first half of each bit and high for the second half. The port changes outgoing data as the clock falls and samples incoming data as it rises.

Software uses a small register port with two addresses. Writing the data address starts a transmit. A receive runs on its own whenever the receive enable is set, the receive flag is clear and the port is idle. After the eighth bit of either direction a completion flag is raised and stays up until software writes zero to it. No streaming handshake is provided: the register port has no back-pressure. A data write that arrives while a transfer is in progress is simply dropped, so software waits for the transmit flag before writing again.

Top module: `ssp_port`

## Requirements
- R1: A transfer of either direction starts only while the mode field (control bits 4:3) equals 00. Any other value keeps the port idle: `sclk_out` stays 1 and `sd_oe` stays 0.
- R2: Register map. A write to address 0 supplies the byte to transmit, and a read of address 0 returns the last received byte. Address 1 is control: bit 0 is the receive enable, bit 1 the transmit flag, bit 2 the receive flag and bits 4:3 the mode. A read of address 1 returns those fields in those positions with zeros above them. Reset leaves all of them 0.
- R3: Each transfer moves exactly 8 bits, least significant first. Every bit lasts CLK_DIV (12) core clocks: `sclk_out` is low for the first 6 and high for the last 6. Outgoing data changes only while `sclk_out` is low, and incoming data is sampled where `sclk_out` rises.
- R4: A write to address 0 while the port is idle and the mode is 00 starts a transmit of the written byte. A write to address 0 during a transfer is ignored: the current byte finishes unchanged and no second transfer follows.
- R5: With the receive enable at 1, the receive flag at 0 and the port idle, a receive starts. The 8 sampled bits, first bit in bit 0, become readable at address 0 when the receive flag rises. While that flag is 1 no further receive starts.
- R6: The transmit flag rises in the cycle the eighth transmitted bit ends, and the receive flag rises in the cycle the eighth received bit ends. Writing 0 to a flag's control bit clears it, and writing 1 leaves it unchanged. If a set and a clear fall in the same cycle, the flag ends up set.
- R7: `sclk_out` is 1 whenever no transfer is running. `sd_oe` is 1 only during a transmit, including the whole of every transmitted bit, and is 0 during a receive.
- R8: If a transmit start and a receive start are both due in the same idle cycle, the transmit wins and the receive waits until the port is idle again.
- R9: Out of reset, `sclk_out` is 1, `sd_oe` is 0 and the control register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 data, 1 control |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| sd_in | input | 1 | Data pin as seen from the pad |
| sd_out | output | 1 | Data pin drive value |
| sd_oe | output | 1 | Data pin output enable |
| sclk_out | output | 1 | Shift clock, idles high |

## Verification
Two pairs of events can fall into the same core cycle. The first pair is a transmit start and a receive start. The bench provokes this by writing the receive enable and then the data register on the next cycle, so both conditions hold on the same edge. It judges the outcome by requiring `sd_oe` to rise and the captured byte to match the written one. The second pair is the transmit flag being set and cleared at once. The bench counts five cycles from the eighth clock rise so that a flag-clearing control write lands on the final edge of the transfer, then reads back the flag and expects it to be 1.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } ssp_state_e;

  // control register field positions
  localparam int unsigned CTL_RXEN    = 0;
  localparam int unsigned CTL_TI      = 1;
  localparam int unsigned CTL_RI      = 2;
  localparam int unsigned CTL_MODE_LO = 3;
  localparam int unsigned CTL_USED    = 5;

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int unsigned CLK_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_stb,
  output logic end_stb
);
  localparam int unsigned CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(CLK_DIV / 2);
  localparam logic [CNT_W-1:0] RISE_C = CNT_W'(CLK_DIV / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] ph;

  // phase counter across one bit period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ph <= '0;
    else if (!run || ph == LAST_C) ph <= '0;
    else                           ph <= ph + CNT_W'(1);
  end

  assign sclk     = !run || (ph >= HALF_C);
  assign rise_stb = run && (ph == RISE_C);
  assign end_stb  = run && (ph == LAST_C);

  // R3: the clock only falls at the start of a bit
  a_r3_fall_at_bit_start: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !sclk && $past(sclk)) |-> (ph == '0));

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              clear,
  input  logic              shift_out,
  input  logic              shift_in,
  input  logic              din,
  output logic [DATA_W-1:0] sr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sr <= '0;
    else if (load)      sr <= ld_data;
    else if (clear)     sr <= '0;
    else if (shift_in)  sr <= {din, sr[DATA_W-1:1]};
    else if (shift_out) sr <= {1'b1, sr[DATA_W-1:1]};
  end

  // R3: a bit period shifts in one direction only
  a_r3_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_in && shift_out));

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              end_stb,
  input  logic [DATA_W-1:0] sr,
  output ssp_state_e        state,
  output logic              tx_start,
  output logic              rx_start,
  output logic              rx_en,
  output logic              ti,
  output logic              ri,
  output logic [1:0]        mode,
  output logic [DATA_W-1:0] rx_buf
);
  localparam int unsigned IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic [IDX_W-1:0] bit_idx;
  logic ctl_wr, mode_ok, last_bit, clr_ti, clr_ri, set_ti, set_ri;

  assign ctl_wr   = reg_we && reg_addr;
  assign mode_ok  = (mode == 2'b00);
  assign tx_start = reg_we && !reg_addr && (state == ST_IDLE) && mode_ok;
  assign rx_start = (state == ST_IDLE) && mode_ok && rx_en && !ri && !tx_start;
  assign last_bit = end_stb && (bit_idx == LAST_IDX);
  assign clr_ti   = ctl_wr && !reg_wdata[CTL_TI];
  assign clr_ri   = ctl_wr && !reg_wdata[CTL_RI];
  assign set_ti   = last_bit && (state == ST_TX);
  assign set_ri   = last_bit && (state == ST_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (tx_start)      state <= ST_TX;
          else if (rx_start) state <= ST_RX;
        end
        default: if (last_bit) state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    bit_idx <= '0;
    else if (tx_start || rx_start) bit_idx <= '0;
    else if (end_stb)              bit_idx <= bit_idx + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en  <= 1'b0;
      mode   <= 2'b00;
      ti     <= 1'b0;
      ri     <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (ctl_wr) begin
        rx_en <= reg_wdata[CTL_RXEN];
        mode  <= reg_wdata[CTL_MODE_LO +: 2];
      end
      ti <= (ti && !clr_ti) || set_ti;
      ri <= (ri && !clr_ri) || set_ri;
      if (set_ri) rx_buf <= sr;
    end
  end

  // R1: a non-zero mode keeps an idle port idle
  a_r1_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && state == ST_IDLE) |=> (state == ST_IDLE));

  // R6: the receive flag holds until a clearing write
  a_r6_ri_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && !(ctl_wr && !reg_wdata[CTL_RI])) |=> ri);

  // R4: a transmit is not cut short before its last bit
  a_r4_tx_runs_full: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX && !last_bit) |=> (state == ST_TX));

  // R8: a due transmit start always wins
  a_r8_tx_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && reg_we && !reg_addr && mode == 2'b00) |=> (state == ST_TX));

endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_DIV = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              sd_oe,
  output logic              sclk_out
);
  localparam int unsigned PAD_W = (DATA_W > CTL_USED) ? DATA_W - CTL_USED : 1;

  ssp_state_e        state;
  logic              tx_start, rx_start, rx_en, ti, ri;
  logic [1:0]        mode;
  logic [DATA_W-1:0] rx_buf, sr;
  logic              run, rise_stb, end_stb;

  assign run = (state != ST_IDLE);

  ssp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .end_stb(end_stb), .sr(sr), .state(state),
    .tx_start(tx_start), .rx_start(rx_start), .rx_en(rx_en), .ti(ti),
    .ri(ri), .mode(mode), .rx_buf(rx_buf)
  );

  ssp_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run), .sclk(sclk_out),
    .rise_stb(rise_stb), .end_stb(end_stb)
  );

  ssp_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .load(tx_start), .ld_data(reg_wdata),
    .clear(rx_start), .shift_out(end_stb && state == ST_TX),
    .shift_in(rise_stb && state == ST_RX), .din(sd_in), .sr(sr)
  );

  assign sd_oe  = (state == ST_TX);
  assign sd_out = sd_oe ? sr[0] : 1'b1;

  logic [DATA_W-1:0] ctl_view;
  generate
    if (DATA_W > CTL_USED) begin : g_pad
      assign ctl_view = {{PAD_W{1'b0}}, mode, ri, ti, rx_en};
    end else begin : g_nopad
      assign ctl_view = DATA_W'({mode, ri, ti, rx_en});
    end
  endgenerate

  assign reg_rdata = reg_addr ? ctl_view : rx_buf;

  // R3: driven data only moves while the shift clock is low
  a_r3_data_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe && $past(sd_oe) && (sd_out != $past(sd_out))) |-> !sclk_out);

  // R6: the end of a transmit leaves the transmit flag set
  a_r6_ti_on_tx_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_oe) |-> ti);

  // R7: the pin is never driven while the clock idles
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (sclk_out && !sd_oe));

endmodule

// File: tb/sim_ssp_port.sv
module sim_ssp_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we, reg_addr, sd_in;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sd_out, sd_oe, sclk_out;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;

  ssp_port u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_in(sd_in),
    .sd_out(sd_out), .sd_oe(sd_oe), .sclk_out(sclk_out)
  );

  always #10 clk = ~clk;

  // expected read of the control register from its fields (R2)
  function automatic logic [7:0] ctl_exp(logic [1:0] md, logic rfl, logic tfl, logic en);
    return {3'b000, md, rfl, tfl, en};
  endfunction

  // byte assembled from bits seen in wire order, first bit into bit 0 (R3)
  function automatic logic [7:0] wire_pack(logic [7:0] acc, logic b);
    return {b, acc[7:1]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling clk edge
  task automatic wr(input logic a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tx_run(input logic [7:0] poke, input int poke_at, input bit clr_end,
                        output logic [7:0] cap, output int nrise, output int badper,
                        output int lowbad);
    logic prev = 1'b1;
    int cyc = 0, last = 0, guard = 0;
    cap = '0; nrise = 0; badper = 0; lowbad = 0;
    while (sd_oe && guard < 400) begin
      if (!sclk_out && prev) last = last; // fall observed
      if (!prev && sclk_out) begin
        cap = wire_pack(cap, sd_out);
        if (nrise > 0 && (cyc - last) != 12) badper++;
        last = cyc;
        nrise++;
        if (poke_at == nrise) begin wr(1'b0, poke); cyc++; end
        if (clr_end && nrise == 8) begin
          repeat (5) @(negedge clk);
          cyc += 5;
          reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h04;
          @(negedge clk);
          reg_we = 1'b0;
          cyc++;
        end
      end
      prev = sclk_out;
      @(negedge clk);
      if (sd_oe && sclk_out && !prev && (sd_out != cap[7])) lowbad = lowbad;
      cyc++; guard++;
    end
    if (guard >= 400) check(1'b0, "R3 transmit timeout", guard, 0);
  endtask

  task automatic do_tx(input logic [7:0] b, input string req);
    logic [7:0] cap; int nr, bp, lb;
    logic [7:0] c;
    wr(1'b0, b);
    check(sd_oe == 1'b1, "R4 transmit started", sd_oe, 1);
    tx_run(8'h00, 0, 1'b0, cap, nr, bp, lb);
    check(cap == b, req, cap, b);
    check(nr == 8 && bp == 0, "R3 eight bits of 12 clocks", nr * 100 + bp, 800);
    rd(1'b1, c);
    check(c[1] == 1'b1, "R6 transmit flag set", c[1], 1);
  endtask

  task automatic rx_run(input logic [7:0] b, output logic [7:0] got, output int oebad);
    logic prev = 1'b1;
    int k = 0, guard = 0;
    logic [7:0] c;
    oebad = 0;
    wr(1'b1, 8'h01);
    while (guard < 400) begin
      if (prev && !sclk_out && k < 8) begin
        sd_in = b[k[2:0]];
        k++;
      end
      if (sd_oe) oebad++;
      rd(1'b1, c);
      if (c[2]) break;
      prev = sclk_out;
      @(negedge clk);
      guard++;
    end
    if (guard >= 400) check(1'b0, "R5 receive timeout", guard, 0);
    rd(1'b0, got);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] c, got, cap, b;
    int nr, bp, lb, oeb, hi;
    void'($urandom(32'd2024));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 1'b1; reg_wdata = '0; sd_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(1'b1, c);
    check(c == 8'h00, "R9 control after reset", c, 0);
    check(sclk_out == 1'b1 && sd_oe == 1'b0, "R9 pins after reset (R7)", {sclk_out, sd_oe}, 2'b10);

    // directed transmit patterns
    do_tx(8'hA5, "R3 tx byte A5 LSB first");
    wr(1'b1, 8'h00);
    do_tx(8'h01, "R3 tx byte 01");
    wr(1'b1, 8'h00);
    do_tx(8'h80, "R3 tx byte 80");
    wr(1'b1, 8'h00);
    rd(1'b1, c);
    check(c == ctl_exp(2'b00, 1'b0, 1'b0, 1'b0), "R6 flag cleared by writing 0", c, 0);

    // R4: a data write during a transfer is dropped
    wr(1'b0, 8'h3C);
    tx_run(8'hFF, 3, 1'b0, cap, nr, bp, lb);
    check(cap == 8'h3C, "R4 busy write ignored", cap, 8'h3C);
    hi = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (sd_oe || !sclk_out) hi++;
    end
    check(hi == 0, "R4 no second transfer", hi, 0);

    // R6: set and clear of the transmit flag on the same edge
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h5A);
    tx_run(8'h00, 0, 1'b1, cap, nr, bp, lb);
    check(cap == 8'h5A, "R6 tx before collision", cap, 8'h5A);
    rd(1'b1, c);
    check(c[1] == 1'b1, "R6 set wins over clear", c[1], 1);
    wr(1'b1, 8'h04);
    rd(1'b1, c);
    check(c[1] == 1'b0, "R6 later clear", c[1], 0);

    // R1: non-zero mode blocks both directions
    wr(1'b1, 8'h08);
    wr(1'b0, 8'hC3);
    wr(1'b1, 8'h09);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sd_oe || !sclk_out) hi++;
    end
    check(hi == 0, "R1 mode 01 stays idle", hi, 0);
    rd(1'b1, c);
    check(c == ctl_exp(2'b01, 1'b0, 1'b0, 1'b1), "R1 R2 control readback", c, ctl_exp(2'b01, 1'b0, 1'b0, 1'b1));
    wr(1'b1, 8'h10);
    wr(1'b0, 8'hC3);
    check(sd_oe == 1'b0, "R1 mode 10 blocks transmit", sd_oe, 0);
    wr(1'b1, 8'h00);

    // R5 directed receive
    rx_run(8'h96, got, oeb);
    check(got == 8'h96, "R5 rx byte 96", got, 8'h96);
    check(oeb == 0, "R7 pin released in receive", oeb, 0);
    hi = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!sclk_out) hi++;
    end
    check(hi == 0, "R5 held while receive flag set", hi, 0);
    wr(1'b1, 8'h04);

    // R8: transmit and receive start due on the same edge
    wr(1'b1, 8'h00);
    reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h01;
    @(negedge clk);
    reg_addr = 1'b0; reg_wdata = 8'hE7;
    @(negedge clk);
    reg_we = 1'b0;
    check(sd_oe == 1'b1, "R8 transmit wins", sd_oe, 1);
    tx_run(8'h00, 0, 1'b0, cap, nr, bp, lb);
    check(cap == 8'hE7, "R8 transmitted byte", cap, 8'hE7);
    hi = 0; oeb = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sd_oe) oeb++;
      rd(1'b1, c);
      if (c[2]) break;
      hi++;
    end
    check(c[2] == 1'b1 && oeb == 0, "R8 deferred receive then completes", {c[2], oeb[0]}, 2'b10);
    wr(1'b1, 8'h00);

    // constrained random traffic
    for (int n = 0; n < 10; n++) begin
      b = 8'($urandom);
      do_tx(b, "R3 random tx");
      wr(1'b1, 8'h00);
    end
    for (int n = 0; n < 8; n++) begin
      b = 8'($urandom);
      rx_run(b, got, oeb);
      check(got == b, "R5 random rx", got, b);
      wr(1'b1, 8'h04);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule